// File: doc/BRIEF.md
# Programmable Sum-of-Products Function Block

This block is a soft model of one function block of a programmable logic device. A group of macrocells shares one input bank. The bank holds the block's external inputs followed by the register outputs of every macrocell. Each macrocell builds several AND terms from mask bits over the true and inverted bank signals. It ORs the terms it keeps, and can then invert the sum or XOR it with a dedicated term. The result goes either straight to the pad or through a register.

A steering stage lets a macrocell take individual terms from the macrocell just above it (index minus one) or just below it (index plus one). Dedicated terms can act as the register's clock, its set, its reset and the pad's output enable. All configuration is a static parallel bus. It is loaded before reset is released and left untouched afterwards.

For macrocell k, the configuration slice starts at bit k*CFG_W, where CFG_W = 8 + 3*N_PT + N_PT*2*W and W = N_IN + N_MC. Bank index i < N_IN is `in_i[i]`. Bank index N_IN+k is the register output of macrocell k.

Top module: `fb_block`

## Requirements
- R1: Mask bit `8+3*N_PT + t*2*W + 2*i` requires bank bit i to be 1 in term t, and bit `+2*i+1` requires it to be 0. A term with no mask bits set evaluates to 1.
- R2: A term with both mask bits set for the same input evaluates to 0.
- R3: The sum of a macrocell is the OR of its own terms whose keep bit (slice bit `8+t`) is set, plus any terms it has borrowed.
- R4: Control bit 0 inverts the sum. Control bit 1 XORs the sum with term 0.
- R5: Take-above bit `8+N_PT+t` claims term t of macrocell k-1, and take-below bit `8+2*N_PT+t` claims term t of macrocell k+1. A claimed term enters the claimer's sum unconditionally and is removed from its home sum.
- R6: If both neighbours claim the same term, the upper neighbour (lower index) receives it and the lower neighbour does not.
- R7: Control bit 7 set sends the combinational result to the pad. When it is clear, the pad shows the register. In global mode (control bit 2 clear), the register loads the result at every clock edge.
- R8: With control bit 2 set, the register loads only at clock edges where term 1 has risen since the previous edge. At all other edges it holds.
- R9: With control bit 4 set, term 3 clears the register at the next edge. With control bit 3 set, term 2 sets it. Clear has priority over set, and both override the load.
- R10: Control bits [6:5] select the output enable: 0 = always on, 1 = off, 2 = term 4, 3 = `goe_i`. A disabled pad drives high impedance and `pad_oe_o` is low.
- R11: The register of macrocell k appears at bank index N_IN+k. It can therefore feed any macrocell in the block.
- R12: A high `rst` at a clock edge clears every register, so registered pads read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock (global clock source) |
| rst | input | 1 | Synchronous active-high reset of all registers |
| in_i | input | N_IN | External inputs of the shared bank |
| goe_i | input | 1 | Global output-enable input |
| cfg_i | input | N_MC*CFG_W | Static configuration bus, one slice per macrocell |
| pad_o | output | N_MC | Pad values, high impedance when disabled |
| pad_oe_o | output | N_MC | Per-pad output enable |

## Verification
The assertions assume that `cfg_i` holds still from reset onward and that `in_i` and `goe_i` change only between clock edges, so every term is settled when it is sampled. The bench writes the whole configuration at time zero, while reset is high. It changes inputs only on falling clock edges and samples one time unit later, or one unit after the next rising edge for registered paths.

// File: rtl/fb_pkg.sv
package fb_pkg;
  localparam int CTL_W  = 8;
  localparam int PT_XOR = 0;
  localparam int PT_CLK = 1;
  localparam int PT_SET = 2;
  localparam int PT_RST = 3;
  localparam int PT_OE  = 4;

  typedef enum logic [1:0] {
    OE_ON  = 2'b00,
    OE_OFF = 2'b01,
    OE_PT  = 2'b10,
    OE_GLB = 2'b11
  } oe_sel_e;

  typedef struct packed {
    logic    bypass;
    oe_sel_e oe_sel;
    logic    rst_en;
    logic    set_en;
    logic    clk_pt;
    logic    xor_en;
    logic    inv;
  } mc_ctl_t;
endpackage

// File: rtl/fb_pterm.sv
module fb_pterm #(
  parameter int W = 54
) (
  input  logic [2*W-1:0] mask_i,
  input  logic [W-1:0]   x_i,
  output logic           term_o
);
  // Each input owns two mask bits: even = require high, odd = require low.
  always_comb begin
    term_o = 1'b1;
    for (int i = 0; i < W; i++) begin
      if (mask_i[2*i]   && !x_i[i]) term_o = 1'b0;
      if (mask_i[2*i+1] &&  x_i[i]) term_o = 1'b0;
    end
  end
endmodule

// File: rtl/fb_alloc.sv
module fb_alloc #(
  parameter int N_MC = 18,
  parameter int N_PT = 5
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [N_MC-1:0][N_PT-1:0]  term_i,
  input  logic [N_MC-1:0][N_PT-1:0]  keep_i,
  input  logic [N_MC-1:0][N_PT-1:0]  take_up_i,
  input  logic [N_MC-1:0][N_PT-1:0]  take_dn_i,
  output logic [N_MC-1:0]            sum_o
);
  // to_up[k][j]: term j of cell k goes to cell k-1; to_dn: to cell k+1.
  logic [N_MC-1:0][N_PT-1:0] to_up, to_dn, at_home;

  for (genvar k = 0; k < N_MC; k++) begin : g_cell
    for (genvar j = 0; j < N_PT; j++) begin : g_term
      if (k > 0) begin : g_up
        assign to_up[k][j] = take_dn_i[k-1][j];
      end else begin : g_noup
        assign to_up[k][j] = 1'b0;
      end
      if (k < N_MC-1) begin : g_dn
        assign to_dn[k][j] = take_up_i[k+1][j] & ~to_up[k][j];
      end else begin : g_nodn
        assign to_dn[k][j] = 1'b0;
      end
      assign at_home[k][j] = keep_i[k][j] & ~to_up[k][j] & ~to_dn[k][j];

      if (k > 0) begin : g_chk_up
        // R5: a true term lent upward lights the upper cell's sum
        a_r5_lend_up: assert property (@(posedge clk) disable iff (rst)
          (term_i[k][j] && to_up[k][j]) |-> sum_o[k-1]);
      end
      if (k < N_MC-1) begin : g_chk_dn
        // R5: a true term lent downward lights the lower cell's sum
        a_r5_lend_dn: assert property (@(posedge clk) disable iff (rst)
          (term_i[k][j] && to_dn[k][j]) |-> sum_o[k+1]);
      end
    end

    logic own_s, from_above, from_below;
    assign own_s = |(term_i[k] & at_home[k]);
    if (k > 0) begin : g_fa
      assign from_above = |(term_i[k-1] & to_dn[k-1]);
    end else begin : g_nfa
      assign from_above = 1'b0;
    end
    if (k < N_MC-1) begin : g_fb
      assign from_below = |(term_i[k+1] & to_up[k+1]);
    end else begin : g_nfb
      assign from_below = 1'b0;
    end
    assign sum_o[k] = own_s | from_above | from_below;
  end
endmodule

// File: rtl/fb_mcell.sv
module fb_mcell
  import fb_pkg::*;
#(
  parameter int N_PT = 5
) (
  input  logic            clk,
  input  logic            rst,
  input  mc_ctl_t         ctl_i,
  input  logic            sum_i,
  input  logic [N_PT-1:0] pt_i,
  input  logic            goe_i,
  output logic            val_o,
  output logic            oe_o,
  output logic            q_o
);
  logic d, q, clk_prev, load, set_c, clr_c;

  assign d     = sum_i ^ ctl_i.inv ^ (ctl_i.xor_en & pt_i[PT_XOR]);
  assign clr_c = ctl_i.rst_en & pt_i[PT_RST];
  assign set_c = ctl_i.set_en & pt_i[PT_SET];
  assign load  = ctl_i.clk_pt ? (pt_i[PT_CLK] & ~clk_prev) : 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      q        <= 1'b0;
      clk_prev <= 1'b0;
    end else begin
      clk_prev <= pt_i[PT_CLK];
      if (clr_c)      q <= 1'b0;
      else if (set_c) q <= 1'b1;
      else if (load)  q <= d;
    end
  end

  always_comb begin
    case (ctl_i.oe_sel)
      OE_ON:   oe_o = 1'b1;
      OE_OFF:  oe_o = 1'b0;
      OE_PT:   oe_o = pt_i[PT_OE];
      default: oe_o = goe_i;
    endcase
  end

  assign val_o = ctl_i.bypass ? d : q;
  assign q_o   = q;

  // R9: clear term beats everything
  a_r9_clear_wins: assert property (@(posedge clk) disable iff (rst)
    clr_c |=> !q_o);
  // R9: set term forces a one when clear is idle
  a_r9_set_forces: assert property (@(posedge clk) disable iff (rst)
    (set_c && !clr_c) |=> q_o);
  // R7: global clock loads every edge
  a_r7_global_load: assert property (@(posedge clk) disable iff (rst)
    (!ctl_i.clk_pt && !clr_c && !set_c) |=> (q_o == $past(d)));
  // R8: term clock holds without a rising term
  a_r8_term_clk_hold: assert property (@(posedge clk) disable iff (rst)
    (ctl_i.clk_pt && !clr_c && !set_c && !(pt_i[PT_CLK] && !clk_prev)) |=> $stable(q_o));
  // R12: reset clears the register
  a_r12_reset_clears: assert property (@(posedge clk)
    rst |=> !q_o);
endmodule

// File: rtl/fb_block.sv
module fb_block
  import fb_pkg::*;
#(
  parameter int N_IN = 36,
  parameter int N_MC = 18,
  parameter int N_PT = 5
) (
  input  logic                                          clk,
  input  logic                                          rst,
  input  logic [N_IN-1:0]                               in_i,
  input  logic                                          goe_i,
  input  logic [N_MC*(CTL_W+3*N_PT+N_PT*2*(N_IN+N_MC))-1:0] cfg_i,
  output logic [N_MC-1:0]                               pad_o,
  output logic [N_MC-1:0]                               pad_oe_o
);
  localparam int W       = N_IN + N_MC;
  localparam int MASK_W  = 2 * W;
  localparam int KEEP_OF = CTL_W;
  localparam int TU_OF   = KEEP_OF + N_PT;
  localparam int TD_OF   = TU_OF + N_PT;
  localparam int MSK_OF  = TD_OF + N_PT;
  localparam int CFG_W   = MSK_OF + N_PT * MASK_W;

  logic [W-1:0]              bank;
  logic [N_MC-1:0]           q_all, val, oe, sum;
  logic [N_MC-1:0][N_PT-1:0] terms, keep, take_up, take_dn;
  mc_ctl_t                   ctl [N_MC];

  assign bank = {q_all, in_i};

  for (genvar k = 0; k < N_MC; k++) begin : g_mc
    logic [CFG_W-1:0] slice;
    assign slice      = cfg_i[k*CFG_W +: CFG_W];
    assign ctl[k]     = slice[CTL_W-1:0];
    assign keep[k]    = slice[KEEP_OF +: N_PT];
    assign take_up[k] = slice[TU_OF +: N_PT];
    assign take_dn[k] = slice[TD_OF +: N_PT];

    for (genvar j = 0; j < N_PT; j++) begin : g_pt
      fb_pterm #(.W(W)) u_pt (
        .mask_i (slice[MSK_OF + j*MASK_W +: MASK_W]),
        .x_i    (bank),
        .term_o (terms[k][j])
      );
    end

    fb_mcell #(.N_PT(N_PT)) u_mc (
      .clk   (clk),
      .rst   (rst),
      .ctl_i (ctl[k]),
      .sum_i (sum[k]),
      .pt_i  (terms[k]),
      .goe_i (goe_i),
      .val_o (val[k]),
      .oe_o  (oe[k]),
      .q_o   (q_all[k])
    );

    assign pad_o[k]    = oe[k] ? val[k] : 1'bz;
    assign pad_oe_o[k] = oe[k];
  end

  fb_alloc #(.N_MC(N_MC), .N_PT(N_PT)) u_alloc (
    .clk       (clk),
    .rst       (rst),
    .term_i    (terms),
    .keep_i    (keep),
    .take_up_i (take_up),
    .take_dn_i (take_dn),
    .sum_o     (sum)
  );
endmodule

// File: tb/tb_fb_block.sv
module tb_fb_block;
  localparam int N_IN  = 36;
  localparam int N_MC  = 18;
  localparam int N_PT  = 5;
  localparam int W     = N_IN + N_MC;
  localparam int KEEPO = 8;
  localparam int TUO   = KEEPO + N_PT;
  localparam int TDO   = TUO + N_PT;
  localparam int MSKO  = TDO + N_PT;
  localparam int CFG_W = MSKO + N_PT * 2 * W;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [N_IN-1:0] in_v = '0;
  logic goe = 1'b0;
  logic [N_MC*CFG_W-1:0] cfg = '0;
  wire  [N_MC-1:0] pad;
  wire  [N_MC-1:0] pad_oe;
  int n_run = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  fb_block #(.N_IN(N_IN), .N_MC(N_MC), .N_PT(N_PT)) dut (
    .clk(clk), .rst(rst), .in_i(in_v), .goe_i(goe), .cfg_i(cfg),
    .pad_o(pad), .pad_oe_o(pad_oe)
  );

  // stimulus table: {goe, in[11:0]}
  localparam logic [12:0] VEC [12] = '{
    13'h0000, 13'h0003, 13'h0004, 13'h0010, 13'h0060, 13'h0020,
    13'h0180, 13'h0200, 13'h0C00, 13'h1800, 13'h0FFF, 13'h1555
  };

  task automatic lit(input int mc, input int t, input int idx, input bit neg);
    cfg[mc*CFG_W + MSKO + t*2*W + 2*idx + int'(neg)] = 1'b1;
  endtask
  task automatic ctl(input int mc, input logic [7:0] c);
    cfg[mc*CFG_W +: 8] = c;
  endtask
  task automatic keep(input int mc, input int t);
    cfg[mc*CFG_W + KEEPO + t] = 1'b1;
  endtask
  task automatic take_up(input int mc, input int t);
    cfg[mc*CFG_W + TUO + t] = 1'b1;
  endtask
  task automatic take_dn(input int mc, input int t);
    cfg[mc*CFG_W + TDO + t] = 1'b1;
  endtask

  task automatic check(input string req, input string what, input logic act, input logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  function automatic string req_of(input int mc);
    case (mc)
      0: return "R3";
      1, 2: return "R4";
      3: return "R1";
      4: return "R2";
      5, 6, 7: return "R5";
      8, 9: return "R6";
      default: return "R10";
    endcase
  endfunction

  function automatic logic [12:0] exp_val(input logic [11:0] a);
    logic [12:0] e;
    e[0]  = (a[0] & a[1]) | (a[2] & ~a[3]);
    e[1]  = ~a[4];
    e[2]  = a[6] ^ a[5];
    e[3]  = 1'b1;
    e[4]  = 1'b0;
    e[5]  = a[8];
    e[6]  = 1'b0;
    e[7]  = a[7] | a[9];
    e[8]  = 1'b0;
    e[9]  = 1'b0;
    e[10] = a[11];
    e[11] = a[11];
    e[12] = a[11];
    return e;
  endfunction

  task automatic reg_step(input logic [3:0] a);
    @(negedge clk);
    in_v = '0;
    in_v[3:0] = a;
    @(posedge clk);
    #1;
  endtask

  initial begin
    #1_500_000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    // combinational cells
    lit(0,0,0,0); lit(0,0,1,0); lit(0,1,2,0); lit(0,1,3,1);
    keep(0,0); keep(0,1); ctl(0, 8'h80);
    lit(1,0,4,0); keep(1,0); ctl(1, 8'h81);
    lit(2,0,5,0); lit(2,1,6,0); keep(2,1); ctl(2, 8'h82);
    keep(3,0); ctl(3, 8'h80);
    lit(4,0,0,0); lit(4,0,0,1); keep(4,0); ctl(4, 8'h80);
    take_dn(5,1); ctl(5, 8'h80);
    lit(6,0,7,0); lit(6,1,8,0); keep(6,0); keep(6,1); ctl(6, 8'h80);
    take_up(7,0); take_dn(7,0); ctl(7, 8'h80);
    lit(8,0,9,0); keep(8,0); ctl(8, 8'h80);
    take_up(9,0); ctl(9, 8'h80);
    lit(10,0,11,0); lit(10,4,10,0); keep(10,0); ctl(10, 8'hC0);
    lit(11,0,11,0); keep(11,0); ctl(11, 8'hE0);
    lit(12,0,11,0); keep(12,0); ctl(12, 8'hA0);
    // registered cells
    lit(13,0,0,0); keep(13,0); ctl(13, 8'h00);
    lit(14,0,0,0); lit(14,1,1,0); keep(14,0); ctl(14, 8'h04);
    lit(15,0,0,0); lit(15,2,2,0); lit(15,3,3,0); keep(15,0); ctl(15, 8'h18);
    lit(16,0,N_IN+13,0); keep(16,0); ctl(16, 8'h80);

    // R12: reset holds registers low even with data high
    in_v[0] = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    check("R12", "pad13 in reset", pad[13], 1'b0);
    check("R12", "pad14 in reset", pad[14], 1'b0);
    check("R12", "pad15 in reset", pad[15], 1'b0);
    check("R11", "pad16 feedback in reset", pad[16], 1'b0);

    // table walk over combinational cells
    for (int v = 0; v < 12; v++) begin
      logic [12:0] e;
      @(negedge clk);
      in_v = '0;
      in_v[11:0] = VEC[v][11:0];
      goe = VEC[v][12];
      #1;
      e = exp_val(VEC[v][11:0]);
      check("R10", "oe10", pad_oe[10], VEC[v][10]);
      check("R10", "oe11", pad_oe[11], VEC[v][12]);
      check("R10", "oe12", pad_oe[12], 1'b0);
      check("R10", "oe0", pad_oe[0], 1'b1);
      for (int m = 0; m < 13; m++) begin
        logic en;
        en = (m == 10) ? VEC[v][10] : (m == 11) ? VEC[v][12] : (m == 12) ? 1'b0 : 1'b1;
        if (en) check(req_of(m), $sformatf("pad%0d vec%0d", m, v), pad[m], e[m]);
      end
    end

    // registered paths
    @(negedge clk);
    rst = 1'b0;
    reg_step(4'b0001);
    check("R7", "pad13 loads 1", pad[13], 1'b1);
    check("R11", "pad16 follows q13", pad[16], 1'b1);
    check("R8", "pad14 no edge", pad[14], 1'b0);
    check("R7", "pad15 loads 1", pad[15], 1'b1);
    reg_step(4'b0011);
    check("R8", "pad14 loads on rise", pad[14], 1'b1);
    reg_step(4'b0010);
    check("R8", "pad14 holds while high", pad[14], 1'b1);
    check("R7", "pad13 loads 0", pad[13], 1'b0);
    check("R11", "pad16 follows q13 low", pad[16], 1'b0);
    reg_step(4'b0000);
    check("R8", "pad14 holds on fall", pad[14], 1'b1);
    reg_step(4'b0010);
    check("R8", "pad14 loads 0 on rise", pad[14], 1'b0);
    reg_step(4'b0100);
    check("R9", "pad15 set", pad[15], 1'b1);
    reg_step(4'b1100);
    check("R9", "pad15 clear beats set", pad[15], 1'b0);
    reg_step(4'b1001);
    check("R9", "pad15 clear beats data", pad[15], 1'b0);
    reg_step(4'b0001);
    check("R7", "pad15 follows data", pad[15], 1'b1);

    // R12: reset again after activity
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    #1;
    check("R12", "pad13 cleared", pad[13], 1'b0);
    check("R12", "pad15 cleared", pad[15], 1'b0);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule